// File: doc/BRIEF.md
# Timer Count-Clock Selector

This block decides, cycle by cycle, whether a 16-bit timer counter advances. The count enable can come from one of several sources: a tap of a free-running internal prescaler at φ/1, φ/4, φ/16, φ/64, φ/256, φ/1024 or φ/4096; one of four external clock pins, each passed through a two-flop synchronizer; or a single-cycle overflow/underflow strobe from another timer channel.

For the divided taps and the external pins, an edge qualifier decides which transitions count: rising, falling or both. The φ/1 source advances the counter on every clock, and the cascade source counts each strobe once. Neither of these two sources looks at the edge setting. When the phase-counting flag is set, this block produces no count pulses at all. The counter wraps from all-ones to zero and flags the wrap for one cycle.

Top module: `tmr_clk_sel`

## Requirements
- R1: While rst_ni is low, count_o is 0x0000 and ovf_o is 0.
- R2: With src_sel_i = 0 (φ/1) and phase_mode_i low, count_o advances by one on every clock, whatever the value of edge_sel_i.
- R3: With src_sel_i = k for k in 1..6, the source is a square wave of period 4^k clocks. With edge_sel_i = 00 (rising) or 01 (falling), count_o advances once per period.
- R4: With edge_sel_i = 1x (both edges) on a divided tap or an external pin, count_o advances twice per source period.
- R5: With src_sel_i = 8 + j, external pin ext_clk_i[j] (j = 0..3) is synchronized and counted on the edge chosen by edge_sel_i.
- R6: With src_sel_i = 12, every clock in which casc_i is high advances count_o by exactly one, whatever the value of edge_sel_i.
- R7: While phase_mode_i is high, no count pulse is produced and count_o holds.
- R8: A change of src_sel_i between divided taps or external pins produces no count pulse in the cycle of the change, even if the old and new source levels differ.
- R9: When count_o is 0xFFFF and a pulse arrives, count_o becomes 0x0000 and ovf_o is high for that one cycle.
- R10: The unused source codes 7, 13, 14 and 15 never advance count_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 4 | Count source: 0 φ/1, 1..6 φ/4..φ/4096, 8..11 pins A..D, 12 cascade |
| edge_sel_i | input | 2 | 00 rising, 01 falling, 1x both edges |
| ext_clk_i | input | 4 | External clock pins, asynchronous |
| casc_i | input | 1 | Overflow/underflow strobe from another channel |
| phase_mode_i | input | 1 | Phase-counting mode active; blocks all counting |
| cnt_en_o | output | 1 | Single-cycle count enable |
| count_o | output | 16 | Counter value |
| ovf_o | output | 1 | One-cycle wrap strobe |

## Verification
The hardest case to reach is a source switch that would look like an edge. For that, the old and new sources must sit at steady and opposite levels at the moment of the switch. Free-running prescaler taps cannot be parked at chosen levels, so the bench holds two external pins at fixed, opposite levels. It lets the synchronizers settle and then moves src_sel_i from one pin to the other, in both the rising and the falling direction, and expects a count delta of zero. Another costly case is the wrap, which needs a full 65,536-cycle run at φ/1 with the overflow strobe counted over the whole run.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned NUM_TAPS = 6;
  localparam int unsigned NUM_EXT  = 4;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PSC_W    = 2 * NUM_TAPS;

  localparam logic [SEL_W-1:0] SRC_DIV1 = 4'd0;
  localparam logic [SEL_W-1:0] SRC_TAP0 = 4'd1;
  localparam logic [SEL_W-1:0] SRC_EXT0 = 4'd8;
  localparam logic [SEL_W-1:0] SRC_CASC = 4'd12;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10
  } edge_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_clk_pkg::*;
#(
  parameter int unsigned N_TAPS = NUM_TAPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [N_TAPS-1:0] tap_o
);
  localparam int unsigned W = 2 * N_TAPS;

  logic [W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // tap k is a square wave of period 4^(k+1)
  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    assign tap_o[k] = div_q[2*k+1];
  end
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_clk_pkg::*;
#(
  parameter int unsigned N_TAPS = NUM_TAPS,
  parameter int unsigned N_EXT  = NUM_EXT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic [N_EXT-1:0]  ext_clk_i,
  input  logic              casc_i,
  input  logic              phase_mode_i,
  output logic              pulse_o
);
  logic [N_EXT-1:0] meta_q, sync_q;
  logic [SEL_W-1:0] sel_q;
  logic             lvl, lvl_q, edge_src, rise, fall, edge_hit;

  for (genvar j = 0; j < N_EXT; j++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[j] <= 1'b0;
        sync_q[j] <= 1'b0;
      end else begin
        meta_q[j] <= ext_clk_i[j];
        sync_q[j] <= meta_q[j];
      end
    end
  end

  always_comb begin
    lvl      = 1'b0;
    edge_src = 1'b0;
    for (int k = 0; k < N_TAPS; k++) begin
      if (src_sel_i == SEL_W'(SRC_TAP0 + k)) begin
        lvl      = tap_i[k];
        edge_src = 1'b1;
      end
    end
    for (int j = 0; j < N_EXT; j++) begin
      if (src_sel_i == SEL_W'(SRC_EXT0 + j)) begin
        lvl      = sync_q[j];
        edge_src = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      sel_q <= SRC_DIV1;
    end else begin
      lvl_q <= lvl;
      sel_q <= src_sel_i;
    end
  end

  // history belongs to the previous source during a switch
  assign rise = lvl & ~lvl_q & (sel_q == src_sel_i);
  assign fall = ~lvl & lvl_q & (sel_q == src_sel_i);

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      default:   edge_hit = rise | fall;
    endcase
  end

  always_comb begin
    if (phase_mode_i)                pulse_o = 1'b0;
    else if (src_sel_i == SRC_DIV1)  pulse_o = 1'b1;
    else if (src_sel_i == SRC_CASC)  pulse_o = casc_i;
    else                             pulse_o = edge_src & edge_hit;
  end

  AST_SWITCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != $past(src_sel_i) && src_sel_i != SRC_DIV1 && src_sel_i != SRC_CASC)
      |-> !pulse_o); // R8
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_clk_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign ovf_o   = cnt_en_i & (&cnt_q);

  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (count_o == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(count_o)); // R10
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_clk_pkg::*;
#(
  parameter int unsigned N_TAPS = NUM_TAPS,
  parameter int unsigned N_EXT  = NUM_EXT,
  parameter int unsigned W      = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [N_EXT-1:0] ext_clk_i,
  input  logic             casc_i,
  input  logic             phase_mode_i,
  output logic             cnt_en_o,
  output logic [W-1:0]     count_o,
  output logic             ovf_o
);
  logic [N_TAPS-1:0] tap;

  tmr_prescaler #(.N_TAPS(N_TAPS)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tap_o (tap)
  );

  tmr_src_sel #(.N_TAPS(N_TAPS), .N_EXT(N_EXT)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_sel_i   (src_sel_i),
    .edge_sel_i  (edge_sel_i),
    .tap_i       (tap),
    .ext_clk_i   (ext_clk_i),
    .casc_i      (casc_i),
    .phase_mode_i(phase_mode_i),
    .pulse_o     (cnt_en_o)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_en_i(cnt_en_o),
    .count_o (count_o),
    .ovf_o   (ovf_o)
  );

  AST_DIV1_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SRC_DIV1 && !phase_mode_i) |=> (count_o == W'($past(count_o) + 1'b1))); // R2
  AST_CASC_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SRC_CASC && casc_i && !phase_mode_i) |=> (count_o == W'($past(count_o) + 1'b1))); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_mode_i |=> $stable(count_o)); // R7
endmodule

// File: tb/tmr_clk_sel_tb.sv
module tmr_clk_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_sel = 4'd0;
  logic [1:0]  edge_sel = 2'b00;
  logic [3:0]  ext_run = 4'h0;
  logic [3:0]  ext_hold = 4'h0;
  logic        gen = 1'b0;
  logic [3:0]  ext_clk;
  logic        casc = 1'b0;
  logic        phase = 1'b0;
  logic        cnt_en;
  logic [15:0] count;
  logic        ovf;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign ext_clk = (ext_run & {4{gen}}) | (~ext_run & ext_hold);

  // external source: period 8 clocks
  initial forever begin
    repeat (4) @(negedge clk);
    gen = ~gen;
  end

  tmr_clk_sel u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_sel_i   (src_sel),
    .edge_sel_i  (edge_sel),
    .ext_clk_i   (ext_clk),
    .casc_i      (casc),
    .phase_mode_i(phase),
    .cnt_en_o    (cnt_en),
    .count_o     (count),
    .ovf_o       (ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] s, input logic [1:0] e);
    src_sel  = s;
    edge_sel = e;
    repeat (8) @(negedge clk);
  endtask

  task automatic window(input int k, output int d);
    logic [15:0] c0;
    c0 = count;
    repeat (k) @(negedge clk);
    d = int'(16'(count - c0));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    check("R1 ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_div1;
    int d;
    for (int e = 0; e < 3; e++) begin
      cfg(4'd0, 2'(e));
      window(40, d);
      check("R2 div1 any edge", d, 40);
    end
  endtask

  task automatic t_taps;
    int d, p;
    for (int k = 1; k <= 6; k++) begin
      p = 1 << (2 * k);
      cfg(4'(k), 2'b00);
      window(3 * p, d);
      check("R3 tap rising", d, 3);
      cfg(4'(k), 2'b10);
      window(3 * p, d);
      check("R4 tap both", d, 6);
      if (k <= 3) begin
        cfg(4'(k), 2'b01);
        window(3 * p, d);
        check("R3 tap falling", d, 3);
        cfg(4'(k), 2'b11);
        window(3 * p, d);
        check("R4 tap both 11", d, 6);
      end
    end
  endtask

  task automatic t_ext;
    int d;
    ext_run = 4'hF;
    for (int j = 0; j < 4; j++) begin
      cfg(4'(8 + j), 2'b00);
      window(40, d);
      check("R5 ext rising", d, 5);
      cfg(4'(8 + j), 2'b01);
      window(40, d);
      check("R5 ext falling", d, 5);
      cfg(4'(8 + j), 2'b10);
      window(40, d);
      check("R4 ext both", d, 10);
    end
  endtask

  task automatic t_casc;
    int d;
    logic [15:0] c0;
    cfg(4'd12, 2'b10);
    c0 = count;
    for (int i = 0; i < 5; i++) begin
      casc = 1'b1;
      @(negedge clk);
      casc = 1'b0;
      repeat (3) @(negedge clk);
    end
    d = int'(16'(count - c0));
    check("R6 cascade strobes", d, 5);
    window(20, d);
    check("R6 no strobe no count", d, 0);
  endtask

  task automatic t_phase;
    int d;
    cfg(4'd0, 2'b00);
    phase = 1'b1;
    @(negedge clk);
    window(30, d);
    check("R7 phase div1", d, 0);
    cfg(4'd8, 2'b10);
    window(40, d);
    check("R7 phase ext", d, 0);
    cfg(4'd1, 2'b00);
    window(40, d);
    check("R7 phase tap", d, 0);
    phase = 1'b0;
  endtask

  task automatic t_switch;
    int d;
    ext_run  = 4'h0;
    ext_hold = 4'b0010;
    cfg(4'd8, 2'b00);
    window(4, d);
    check("R8 held pin idle", d, 0);
    src_sel = 4'd9;
    window(8, d);
    check("R8 switch low->high rising", d, 0);
    edge_sel = 2'b01;
    @(negedge clk);
    src_sel = 4'd8;
    window(8, d);
    check("R8 switch high->low falling", d, 0);
  endtask

  task automatic t_unused;
    int d;
    ext_run = 4'hF;
    for (int s = 7; s < 16; s++) begin
      if (s == 7 || s >= 13) begin
        cfg(4'(s), 2'b10);
        window(40, d);
        check("R10 unused code", d, 0);
      end
    end
    ext_run = 4'h0;
  endtask

  task automatic t_wrap;
    int d, n_ovf;
    logic [15:0] c0;
    rst_n = 1'b0;
    src_sel = 4'd0;
    edge_sel = 2'b01;
    @(negedge clk);
    rst_n = 1'b1;
    c0 = count;
    n_ovf = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (ovf) n_ovf++;
    end
    d = int'(16'(count - c0));
    check("R9 wrap delta", d, 0);
    check("R9 single ovf strobe", n_ovf, 1);
  endtask

  initial begin
    t_reset();
    t_div1();
    t_taps();
    t_ext();
    t_casc();
    t_phase();
    t_switch();
    t_unused();
    t_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule